// File: doc/BRIEF.md
# Interrupt-Triggered Descriptor Transfer Engine

This block moves one data item between a peripheral register address and a memory buffer each time a peripheral signals an interrupt, so that no processor software runs for routine transfers. A single channel descriptor holds an I/O-side address pointer, a buffer-side address pointer, a transfer counter, a five-bit control field, an enable flag and a two-bit completion code. Software loads the descriptor through a plain load strobe while the engine is idle. It then reads back the pointers, counter, enable and code through status outputs.

A request pulse starts a multi-cycle sequence. The engine reads the descriptor and checks for a peripheral termination request. It then moves one byte, or two bytes for a word, over a byte-wide bus master, and steps the pointers and the counter. The sequence ends in one of two ways. It can acknowledge the peripheral and return quietly. It can instead end the channel and raise a normal processor interrupt. The bus request side is valid/ready: the engine holds `bus_valid` with a stable address, direction and write data until it samples `bus_ready` high. Only one request is outstanding at a time. A read is answered by a single-cycle `bus_rvalid` pulse, which the engine always accepts. The response must come on a later cycle than the accepting edge.

Top module: `tdx_engine`

## Requirements
- R1: If the enable flag is 0 when a request is taken, the engine makes no bus access, leaves the descriptor unchanged, never raises `busy`, and pulses `cpu_irq` on the edge that takes the request.
- R2: If control bit 4 (termination allowed) is 1 and `term_req` is high in the check cycle, no data moves and pointers and counter stay unchanged. The code becomes 11, the enable flag clears and `cpu_irq` pulses.
- R3: Control bit 0 selects the direction. With 0, bytes go from the I/O pointer's address to the buffer pointer's address. With 1, bytes go from the buffer address to the I/O address.
- R4: Control bit 2 = 1 holds the I/O pointer fixed and 0 lets it step. Control bit 3 does the same for the buffer pointer.
- R5: Control bit 1 selects word transfers. A word moves as two bytes at pointer+0 and then pointer+1, and a stepping pointer advances by 2. A byte transfer steps by 1.
- R6: Each completed transfer lowers the counter by exactly 1, modulo 2^CW, so a counter of 0 wraps to all ones.
- R7: When the counter reaches 0 after a transfer, the code becomes 01, the enable flag clears, `cpu_irq` pulses and `irq_ack` stays low.
- R8: When the counter is nonzero after a transfer, the code becomes 00, the enable flag stays set, `irq_ack` pulses and `cpu_irq` stays low. The two pulses never coincide.
- R9: A bus request, once valid, keeps its address, `bus_we` and `bus_wdata` stable until accepted.
- R10: `busy` is high from the accepting edge of an enabled request until the finishing edge, and `bus_valid` is low whenever `busy` is low. A request pulse that arrives while busy is held and served after the current sequence ends.
- R11: After reset the enable flag is 0, the code is 00, and `busy`, `bus_valid`, `cpu_irq` and `irq_ack` are low. A descriptor load clears the code to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pulse | input | 1 | Peripheral service request, one-cycle pulse |
| term_req | input | 1 | Peripheral termination request, level |
| irq_ack | output | 1 | One-cycle pulse clearing the peripheral request |
| cpu_irq | output | 1 | One-cycle pulse raising a normal processor interrupt |
| busy | output | 1 | Sequence in progress |
| cfg_load | input | 1 | Load descriptor (taken only when idle) |
| cfg_enable | input | 1 | Enable flag value to load |
| cfg_ctrl | input | 5 | Control: [0] direction, [1] word, [2] I/O fixed, [3] buffer fixed, [4] termination allowed |
| cfg_ioa | input | AW | I/O pointer value to load |
| cfg_bap | input | AW | Buffer pointer value to load |
| cfg_dct | input | CW | Counter value to load |
| st_enable | output | 1 | Current enable flag |
| st_code | output | 2 | Completion code: 00 more, 01 count done, 11 terminated |
| st_ioa | output | AW | Current I/O pointer |
| st_bap | output | AW | Current buffer pointer |
| st_dct | output | CW | Current counter |
| bus_valid | output | 1 | Bus request valid |
| bus_ready | input | 1 | Bus request accepted when high with valid |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | AW | Byte address |
| bus_wdata | output | 8 | Write byte |
| bus_rvalid | input | 1 | Read data valid pulse |
| bus_rdata | input | 8 | Read byte |

## Verification
The bench builds the engine with 8-bit pointers and a 4-bit counter. A 256-byte memory model can then cover the whole address space, and counter wraparound is reached in a single transfer. All 32 control encodings are swept, each with the termination request low and high, against an arithmetic memory and pointer model, under a bus that withholds ready on a repeating pattern. Dedicated cases cover the disabled channel, the wrap from zero and a request that arrives while busy.

// File: rtl/tdx_pkg.sv
package tdx_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DESC,
    S_RD,
    S_RWAIT,
    S_WR,
    S_UPD,
    S_FIN
  } seq_state_e;

  typedef struct packed {
    logic term_en;
    logic buf_fix;
    logic io_fix;
    logic word;
    logic dir;
  } ctrl_t;

  localparam logic [1:0] CODE_MORE = 2'b00;
  localparam logic [1:0] CODE_DONE = 2'b01;
  localparam logic [1:0] CODE_TERM = 2'b11;

endpackage

// File: rtl/tdx_ptr_step.sv
module tdx_ptr_step #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] ptr,
  input  logic          fix,
  input  logic          word,
  output logic [AW-1:0] nxt
);
  localparam logic [AW-1:0] STEP_B = AW'(1);
  localparam logic [AW-1:0] STEP_W = AW'(2);

  always_comb begin
    if (fix) nxt = ptr;
    else     nxt = ptr + (word ? STEP_W : STEP_B);
  end
endmodule

// File: rtl/tdx_desc_regs.sv
module tdx_desc_regs
  import tdx_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          load_en,
  input  ctrl_t         load_ctrl,
  input  logic [AW-1:0] load_ioa,
  input  logic [AW-1:0] load_bap,
  input  logic [CW-1:0] load_dct,
  input  logic          upd,
  input  logic [AW-1:0] ioa_nxt,
  input  logic [AW-1:0] bap_nxt,
  input  logic          set_code,
  input  logic [1:0]    code_val,
  input  logic          clr_en,
  output logic          en,
  output ctrl_t         ctrl,
  output logic [AW-1:0] ioa,
  output logic [AW-1:0] bap,
  output logic [CW-1:0] dct,
  output logic [1:0]    code
);
  localparam logic [CW-1:0] ONE = CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      ctrl <= '0;
      ioa  <= '0;
      bap  <= '0;
      dct  <= '0;
      code <= CODE_MORE;
    end else if (load) begin
      en   <= load_en;
      ctrl <= load_ctrl;
      ioa  <= load_ioa;
      bap  <= load_bap;
      dct  <= load_dct;
      code <= CODE_MORE;
    end else begin
      if (upd) begin
        ioa <= ioa_nxt;
        bap <= bap_nxt;
        dct <= dct - ONE;
      end
      if (set_code) code <= code_val;
      if (clr_en)   en   <= 1'b0;
    end
  end
endmodule

// File: rtl/tdx_seq.sv
module tdx_seq
  import tdx_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_pulse,
  input  logic          term_req,
  input  logic          en,
  input  ctrl_t         ctrl,
  input  logic [AW-1:0] ioa,
  input  logic [AW-1:0] bap,
  input  logic          dct_zero,
  output logic          busy,
  output logic          upd,
  output logic          set_code,
  output logic [1:0]    code_val,
  output logic          clr_en,
  output logic          cpu_irq,
  output logic          irq_ack,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  input  logic          bus_rvalid,
  input  logic [7:0]    bus_rdata
);
  seq_state_e    state;
  logic          idx;
  logic [7:0]    dbuf;
  logic          pend;
  logic          go;
  logic [AW-1:0] src_base;
  logic [AW-1:0] dst_base;
  logic          do_term;

  assign go       = irq_pulse || pend;
  assign busy     = (state != S_IDLE);
  assign src_base = ctrl.dir ? bap : ioa;
  assign dst_base = ctrl.dir ? ioa : bap;
  assign do_term  = ctrl.term_en && term_req;

  always_comb begin
    bus_valid = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = src_base + AW'(idx);
    bus_wdata = dbuf;
    upd       = 1'b0;
    set_code  = 1'b0;
    code_val  = CODE_MORE;
    clr_en    = 1'b0;
    unique case (state)
      S_DESC: begin
        if (do_term) begin
          set_code = 1'b1;
          code_val = CODE_TERM;
          clr_en   = 1'b1;
        end
      end
      S_RD: bus_valid = 1'b1;
      S_WR: begin
        bus_valid = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = dst_base + AW'(idx);
      end
      S_UPD: upd = 1'b1;
      S_FIN: begin
        set_code = 1'b1;
        if (dct_zero) begin
          code_val = CODE_DONE;
          clr_en   = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      idx     <= 1'b0;
      dbuf    <= '0;
      pend    <= 1'b0;
      cpu_irq <= 1'b0;
      irq_ack <= 1'b0;
    end else begin
      cpu_irq <= 1'b0;
      irq_ack <= 1'b0;
      if (state != S_IDLE && irq_pulse) pend <= 1'b1;
      unique case (state)
        S_IDLE: begin
          if (go) begin
            pend <= 1'b0;
            if (en) state   <= S_DESC;
            else    cpu_irq <= 1'b1;
          end
        end
        S_DESC: begin
          idx <= 1'b0;
          if (do_term) begin
            cpu_irq <= 1'b1;
            state   <= S_IDLE;
          end else begin
            state <= S_RD;
          end
        end
        S_RD: if (bus_ready) state <= S_RWAIT;
        S_RWAIT: begin
          if (bus_rvalid) begin
            dbuf  <= bus_rdata;
            state <= S_WR;
          end
        end
        S_WR: begin
          if (bus_ready) begin
            if (ctrl.word && !idx) begin
              idx   <= 1'b1;
              state <= S_RD;
            end else begin
              state <= S_UPD;
            end
          end
        end
        S_UPD: state <= S_FIN;
        S_FIN: begin
          if (dct_zero) cpu_irq <= 1'b1;
          else          irq_ack <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tdx_engine.sv
module tdx_engine
  import tdx_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_pulse,
  input  logic          term_req,
  output logic          irq_ack,
  output logic          cpu_irq,
  output logic          busy,
  input  logic          cfg_load,
  input  logic          cfg_enable,
  input  logic [4:0]    cfg_ctrl,
  input  logic [AW-1:0] cfg_ioa,
  input  logic [AW-1:0] cfg_bap,
  input  logic [CW-1:0] cfg_dct,
  output logic          st_enable,
  output logic [1:0]    st_code,
  output logic [AW-1:0] st_ioa,
  output logic [AW-1:0] st_bap,
  output logic [CW-1:0] st_dct,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  input  logic          bus_rvalid,
  input  logic [7:0]    bus_rdata
);
  localparam int NPTR = 2;

  ctrl_t         ctrl;
  logic          upd, set_code, clr_en;
  logic [1:0]    code_val;
  logic [AW-1:0] ptr_cur [NPTR];
  logic [AW-1:0] ptr_nxt [NPTR];
  logic          ptr_fix [NPTR];

  assign ptr_cur[0] = st_ioa;
  assign ptr_cur[1] = st_bap;
  assign ptr_fix[0] = ctrl.io_fix;
  assign ptr_fix[1] = ctrl.buf_fix;

  for (genvar g = 0; g < NPTR; g++) begin : g_step
    tdx_ptr_step #(.AW(AW)) u_step (
      .ptr  (ptr_cur[g]),
      .fix  (ptr_fix[g]),
      .word (ctrl.word),
      .nxt  (ptr_nxt[g])
    );
  end

  tdx_desc_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cfg_load && !busy),
    .load_en   (cfg_enable),
    .load_ctrl (ctrl_t'(cfg_ctrl)),
    .load_ioa  (cfg_ioa),
    .load_bap  (cfg_bap),
    .load_dct  (cfg_dct),
    .upd       (upd),
    .ioa_nxt   (ptr_nxt[0]),
    .bap_nxt   (ptr_nxt[1]),
    .set_code  (set_code),
    .code_val  (code_val),
    .clr_en    (clr_en),
    .en        (st_enable),
    .ctrl      (ctrl),
    .ioa       (st_ioa),
    .bap       (st_bap),
    .dct       (st_dct),
    .code      (st_code)
  );

  tdx_seq #(.AW(AW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_pulse  (irq_pulse),
    .term_req   (term_req),
    .en         (st_enable),
    .ctrl       (ctrl),
    .ioa        (st_ioa),
    .bap        (st_bap),
    .dct_zero   (st_dct == '0),
    .busy       (busy),
    .upd        (upd),
    .set_code   (set_code),
    .code_val   (code_val),
    .clr_en     (clr_en),
    .cpu_irq    (cpu_irq),
    .irq_ack    (irq_ack),
    .bus_valid  (bus_valid),
    .bus_ready  (bus_ready),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rvalid (bus_rvalid),
    .bus_rdata  (bus_rdata)
  );
endmodule

// File: rtl/tdx_engine_chk.sv
module tdx_engine_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_ack,
  input logic          cpu_irq,
  input logic          busy,
  input logic          st_enable,
  input logic [1:0]    st_code,
  input logic [CW-1:0] st_dct,
  input logic          bus_valid,
  input logic          bus_ready,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [7:0]    bus_wdata
);
  // R9: an unaccepted request stays valid and unchanged
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_we)
                               && $stable(bus_wdata));

  // R10: no bus traffic outside a sequence
  p_idle_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_valid);

  // R8: acknowledge and interrupt are exclusive
  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_irq && irq_ack));

  // R8: acknowledge leaves the channel enabled with code 00
  p_ack_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> st_enable && st_code == 2'b00);

  // R7 / R2: an interrupt that ends a sequence disables the channel with an ending code
  p_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq && $past(busy) |-> !st_enable && (st_code == 2'b01 || st_code == 2'b11));

  // R1: an interrupt raised without a sequence comes from a disabled channel
  p_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq && !$past(busy) |-> !$past(st_enable) && $stable(st_dct));
endmodule

bind tdx_engine tdx_engine_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_ack   (irq_ack),
  .cpu_irq   (cpu_irq),
  .busy      (busy),
  .st_enable (st_enable),
  .st_code   (st_code),
  .st_dct    (st_dct),
  .bus_valid (bus_valid),
  .bus_ready (bus_ready),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata)
);

// File: tb/tdx_engine_tb_top.sv
module tdx_engine_tb_top;
  localparam int AW = 8;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          irq_pulse = 1'b0;
  logic          term_req = 1'b0;
  logic          irq_ack, cpu_irq, busy;
  logic          cfg_load = 1'b0;
  logic          cfg_enable = 1'b0;
  logic [4:0]    cfg_ctrl = '0;
  logic [AW-1:0] cfg_ioa = '0;
  logic [AW-1:0] cfg_bap = '0;
  logic [CW-1:0] cfg_dct = '0;
  logic          st_enable;
  logic [1:0]    st_code;
  logic [AW-1:0] st_ioa, st_bap;
  logic [CW-1:0] st_dct;
  logic          bus_valid, bus_we;
  logic          bus_ready;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata;
  logic          bus_rvalid = 1'b0;
  logic [7:0]    bus_rdata = '0;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] mem  [256];
  logic [7:0] emem [256];
  logic [7:0] cyc = '0;
  logic       fill_req = 1'b0;
  logic [7:0] fill_seed = '0;
  logic       saw_busy = 1'b0;
  logic       saw_bus  = 1'b0;
  logic       clr_mon  = 1'b0;

  always #2 clk = ~clk;

  tdx_engine #(.AW(AW), .CW(CW)) dut_i (.*);

  function automatic logic [7:0] pat(input int a, input logic [7:0] s);
    return 8'(a * 7 + 3) ^ s;
  endfunction

  assign bus_ready = (cyc[1:0] != 2'b01);

  always @(posedge clk) begin
    cyc <= cyc + 8'd1;
    bus_rvalid <= 1'b0;
    if (fill_req) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(i, fill_seed);
    end else if (bus_valid && bus_ready) begin
      if (bus_we) mem[bus_addr] <= bus_wdata;
      else begin
        bus_rvalid <= 1'b1;
        bus_rdata  <= mem[bus_addr];
      end
    end
  end

  always @(negedge clk) begin
    if (clr_mon) begin
      saw_busy <= 1'b0;
      saw_bus  <= 1'b0;
    end else begin
      if (busy)      saw_busy <= 1'b1;
      if (bus_valid) saw_bus  <= 1'b1;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fill(input logic [7:0] s);
    @(negedge clk);
    fill_seed = s;
    fill_req  = 1'b1;
    @(negedge clk);
    fill_req  = 1'b0;
    for (int i = 0; i < 256; i++) emem[i] = pat(i, s);
  endtask

  task automatic load(input logic [7:0] io, input logic [7:0] bp, input logic [3:0] d,
                      input logic [4:0] c, input logic e);
    @(negedge clk);
    cfg_ioa = io; cfg_bap = bp; cfg_dct = d; cfg_ctrl = c; cfg_enable = e;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic fire();
    @(negedge clk);
    irq_pulse = 1'b1;
    @(negedge clk);
    irq_pulse = 1'b0;
  endtask

  // kind: 1 cpu_irq, 2 irq_ack, 0 timeout (counted as a failure)
  task automatic wait_evt(output int kind);
    kind = 0;
    for (int t = 0; t < 2000; t++) begin
      if (cpu_irq) begin kind = 1; break; end
      if (irq_ack) begin kind = 2; break; end
      @(negedge clk);
    end
    if (kind == 0) check(1'b0, "watchdog", 0, 1);
  endtask

  task automatic wait_next(output int kind);
    @(negedge clk);
    wait_evt(kind);
  endtask

  task automatic model_xfer(input logic [4:0] c, inout logic [7:0] io, inout logic [7:0] bp);
    int nb = c[1] ? 2 : 1;
    for (int b = 0; b < nb; b++) begin
      if (c[0]) emem[8'(io + 8'(b))] = emem[8'(bp + 8'(b))];
      else      emem[8'(bp + 8'(b))] = emem[8'(io + 8'(b))];
    end
    if (!c[2]) io = io + 8'(nb);
    if (!c[3]) bp = bp + 8'(nb);
  endtask

  task automatic check_mem(input string tag);
    int bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== emem[i]) bad++;
    check(bad == 0, tag, bad, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    int kind;
    logic [7:0] eio, ebp;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(!st_enable && st_code == 2'b00, "R11 reset flags", {st_enable, st_code}, 0);
    check(!busy && !bus_valid && !cpu_irq && !irq_ack, "R11 reset outputs",
          {busy, bus_valid, cpu_irq, irq_ack}, 0);
    rst_n = 1'b1;

    // R2..R8 sweep over every control encoding with and without termination
    for (int c = 0; c < 32; c++) begin
      for (int t = 0; t < 2; t++) begin
        logic [4:0] cc = 5'(c);
        fill(8'(c * 5 + t));
        load(8'h10, 8'h80, 4'd2, cc, 1'b1);
        check(st_code == 2'b00 && st_enable, "R11 load clears code", st_code, 0);
        eio = 8'h10; ebp = 8'h80;
        term_req = t[0];
        fire();
        wait_evt(kind);
        if (cc[4] && t == 1) begin
          check(kind == 1, "R2 term raises cpu_irq", kind, 1);
          check(st_code == 2'b11 && !st_enable, "R2 term code/enable",
                {st_enable, st_code}, 3);
          check(st_ioa == eio && st_bap == ebp && st_dct == 4'd2, "R2 descriptor kept",
                {st_ioa, st_bap, st_dct}, {eio, ebp, 4'd2});
          check_mem("R2 no transfer");
        end else begin
          model_xfer(cc, eio, ebp);
          check(kind == 2, "R8 ack on nonzero count", kind, 2);
          check(st_code == 2'b00 && st_enable, "R8 code/enable", {st_enable, st_code}, 4);
          check(st_dct == 4'd1, "R6 decrement", st_dct, 1);
          check(st_ioa == eio, "R4 R5 io pointer", st_ioa, eio);
          check(st_bap == ebp, "R4 R5 buf pointer", st_bap, ebp);
          check_mem("R3 R5 data moved");
          term_req = 1'b0;
          fire();
          wait_evt(kind);
          model_xfer(cc, eio, ebp);
          check(kind == 1, "R7 cpu_irq on zero count", kind, 1);
          check(st_code == 2'b01 && !st_enable, "R7 code/enable", {st_enable, st_code}, 1);
          check(st_dct == 4'd0, "R6 reaches zero", st_dct, 0);
          check(st_ioa == eio && st_bap == ebp, "R4 second step",
                {st_ioa, st_bap}, {eio, ebp});
          check_mem("R3 second transfer");
        end
        term_req = 1'b0;
      end
    end

    // R1: disabled channel
    fill(8'h33);
    load(8'h20, 8'h90, 4'd5, 5'b00000, 1'b0);
    @(negedge clk); clr_mon = 1'b1; @(negedge clk); clr_mon = 1'b0;
    fire();
    wait_evt(kind);
    check(kind == 1, "R1 immediate cpu_irq", kind, 1);
    repeat (3) @(negedge clk);
    check(!saw_busy && !saw_bus, "R1 no busy/bus", {saw_busy, saw_bus}, 0);
    check(st_dct == 4'd5 && st_ioa == 8'h20 && st_bap == 8'h90 && st_code == 2'b00,
          "R1 descriptor unchanged", st_dct, 5);
    check_mem("R1 memory unchanged");

    // R6: wrap from zero
    fill(8'h44);
    load(8'h30, 8'hA0, 4'd0, 5'b00000, 1'b1);
    fire();
    wait_evt(kind);
    check(kind == 2, "R6 wrap gives ack", kind, 2);
    check(st_dct == 4'hF, "R6 wrap value", st_dct, 15);

    // R10: request while busy is held pending
    fill(8'h55);
    load(8'h40, 8'hB0, 4'd3, 5'b00000, 1'b1);
    eio = 8'h40; ebp = 8'hB0;
    fire();
    @(negedge clk);
    check(busy, "R10 busy during sequence", busy, 1);
    irq_pulse = 1'b1;
    @(negedge clk);
    irq_pulse = 1'b0;
    wait_evt(kind);
    check(kind == 2 && st_dct == 4'd2, "R10 first service", st_dct, 2);
    wait_next(kind);
    check(kind == 2 && st_dct == 4'd1, "R10 pending served", st_dct, 1);
    model_xfer(5'b00000, eio, ebp);
    model_xfer(5'b00000, eio, ebp);
    check_mem("R10 two transfers");
    repeat (4) @(negedge clk);
    check(!busy && st_dct == 4'd1, "R10 no extra service", st_dct, 1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule